// File: doc/BRIEF.md
# Transmit Descriptor Walker

The block is a bus-master engine that feeds a transmit FIFO from a linked list of descriptors in host memory. Each descriptor is three 32-bit words at a dword-aligned address. The word at offset 0 is the link to the next descriptor, where zero means none. The word at offset 4 is the command/status word. The word at offset 8 is the byte address of the data buffer. The engine reads a descriptor and checks whether the host has handed it over. If so, it streams the buffer into the FIFO in capped bursts, returns the descriptor to the host with status, and follows the link.

Memory traffic uses a request/completion handshake. The engine holds `mem_req` with address, byte length and direction until a one-cycle `mem_done`. Read data arrives one word at a time on `mem_rvalid`/`mem_rdata` before `mem_done`. The seven states are idle, refresh, descriptor read, FIFO block, fragment read, descriptor write and advance. The transitions are:

- idle to refresh or to descriptor read, on a start pulse
- descriptor read to FIFO block when the descriptor is owned, or back to idle when it is not
- FIFO block to fragment read when space allows, or to descriptor write when the fragment is used up
- fragment read back to FIFO block
- descriptor write to advance
- refresh to advance
- advance to descriptor read on a non-null link, or to idle on a null link

Top module: `txd_walker`

## Requirements
- R1: After reset the engine is idle (`eng_state` = 0), `desc_ptr` is 0, and `mem_req` and `fifo_wr` are low; while idle no request is made.
- R2: A `tx_go` pulse in idle with no completed descriptor pending issues a 12-byte read at `desc_ptr` (descriptor read, `eng_state` = 2); a request keeps its address and length until `mem_done`.
- R3: When the fetched command/status word has bit 31 (OWN) clear, the engine returns to idle with no FIFO write and no write-back.
- R4: The buffer is read in bursts of at most MAX_BURST bytes at consecutive addresses; each FIFO write carries a little-endian word with `fifo_nbytes` valid low bytes (4, or the remainder on the last word). Buffers are dword aligned and MAX_BURST is a multiple of 4.
- R5: A fragment read is issued only when `fifo_space` is at least the burst length; otherwise the engine waits in FIFO block (`eng_state` = 3).
- R6: The descriptor cache holds one fragment: the byte count is bits 11:0 of the command/status word. When the count reaches zero, the descriptor is written back and the link is followed, so a packet with bit 30 (MORE) set continues in the next descriptor.
- R7: On the last descriptor of a packet (MORE clear), the engine writes to `desc_ptr`+4 the command/status word with OWN cleared and bits 26 (abort), 25 (underrun) and 24 (carrier lost) taken from `tx_stat[2:0]`; all other bits are kept.
- R8: On a descriptor with MORE set, the write-back clears OWN and bits 26:24 and keeps all other bits.
- R9: In advance a non-null link is loaded into `desc_ptr` and fetched. A null link returns to idle with `desc_ptr` unchanged and marks that descriptor as completed.
- R10: A `tx_go` while a completed descriptor is pending first re-reads 4 bytes (the link) at `desc_ptr`, then advances.
- R11: `ptr_load` in idle loads `ptr_wdata` into `desc_ptr` and clears the completed mark.
- R12: A descriptor with byte count 0 causes no fragment read and is written back directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_go | input | 1 | Start pulse |
| ptr_load | input | 1 | Load descriptor pointer (idle only) |
| ptr_wdata | input | 32 | New descriptor pointer |
| tx_stat | input | 3 | {abort, underrun, carrier lost} for the last write-back |
| fifo_space | input | SPACE_W | Free FIFO bytes |
| mem_req | output | 1 | Memory request, held until done |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_len | output | 12 | Byte length |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data word |
| mem_rvalid | input | 1 | Read data word valid |
| mem_done | input | 1 | Completion pulse |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 32 | FIFO word |
| fifo_nbytes | output | 3 | Valid low bytes in the FIFO word |
| desc_ptr | output | 32 | Current descriptor pointer |
| eng_idle | output | 1 | Engine in idle |
| eng_state | output | 3 | State code: 0 idle, 1 refresh, 2 descriptor read, 3 FIFO block, 4 fragment read, 5 descriptor write, 6 advance |

## Verification
The bench builds the walker with MAX_BURST = 16 and a 12-bit space count. With these values a 20-byte fragment splits into a full burst and a 4-byte tail, and a 6-byte fragment ends in a partial word. A FIFO space of 8 bytes is smaller than one burst, so the stall in FIFO block can be held and then released. Short descriptor chains exercise the link path through both a null and a non-null link, which reaches the refresh path after an end-of-list stop and the zero-length descriptor.

// File: rtl/txd_pkg.sv
package txd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_REFRESH  = 3'd1,
        ST_DREAD    = 3'd2,
        ST_FBLOCK   = 3'd3,
        ST_FREAD    = 3'd4,
        ST_DWRITE   = 3'd5,
        ST_ADVANCE  = 3'd6
    } txd_state_e;

    localparam int OWN_POS  = 31;
    localparam int MORE_POS = 30;
    localparam int STAT_MSB = 26;
    localparam int STAT_LSB = 24;
    localparam int CNT_W    = 12;

    localparam logic [CNT_W-1:0] DESC_LEN = 12'd12;
    localparam logic [CNT_W-1:0] WORD_LEN = 12'd4;
endpackage

// File: rtl/txd_walk_fsm.sv
module txd_walk_fsm
    import txd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       ptr_load,
    input  logic       mem_done,
    input  logic       owned,
    input  logic       resume,
    input  logic       frag_empty,
    input  logic       space_ok,
    input  logic       link_null,
    output txd_state_e state
);
    txd_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (go && !ptr_load) nxt = resume ? ST_REFRESH : ST_DREAD;
            ST_REFRESH: if (mem_done) nxt = ST_ADVANCE;
            ST_DREAD:   if (mem_done) nxt = owned ? ST_FBLOCK : ST_IDLE;
            ST_FBLOCK: begin
                if (frag_empty)    nxt = ST_DWRITE;
                else if (space_ok) nxt = ST_FREAD;
            end
            ST_FREAD:   if (mem_done) nxt = ST_FBLOCK;
            ST_DWRITE:  if (mem_done) nxt = ST_ADVANCE;
            ST_ADVANCE: nxt = link_null ? ST_IDLE : ST_DREAD;
            default:    nxt = ST_IDLE;
        endcase
    end

    // R3: an unowned descriptor never leads into data movement
    p_unowned_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DREAD && mem_done && !owned) |=> state == ST_IDLE);
endmodule

// File: rtl/txd_desc_cache.sv
module txd_desc_cache
    import txd_pkg::*;
#(
    parameter int MAX_BURST = 64,
    parameter int SPACE_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  txd_state_e         state,
    input  logic               ptr_load,
    input  logic [31:0]        ptr_wdata,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata,
    input  logic               mem_done,
    input  logic [SPACE_W-1:0] fifo_space,
    output logic [31:0]        ptr,
    output logic [31:0]        cmdsts,
    output logic [31:0]        bufptr,
    output logic [CNT_W-1:0]   cur_len,
    output logic [CNT_W-1:0]   xfer_left,
    output logic               owned,
    output logic               resume,
    output logic               frag_empty,
    output logic               space_ok,
    output logic               link_null
);
    localparam logic [CNT_W-1:0] BURST_CAP = CNT_W'(MAX_BURST);

    logic [31:0]      link;
    logic [CNT_W-1:0] frag_left;
    logic [CNT_W-1:0] burst;
    logic [1:0]       word_idx;
    logic             fetching;

    assign fetching   = (state == ST_DREAD) || (state == ST_REFRESH);
    assign burst      = (frag_left < BURST_CAP) ? frag_left : BURST_CAP;
    assign space_ok   = 32'(fifo_space) >= 32'(burst);
    assign owned      = cmdsts[OWN_POS];
    assign frag_empty = (frag_left == '0);
    assign link_null  = (link == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            link      <= '0;
            cmdsts    <= '0;
            bufptr    <= '0;
            frag_left <= '0;
            cur_len   <= '0;
            xfer_left <= '0;
            word_idx  <= '0;
            resume    <= 1'b0;
        end else begin
            if (state == ST_IDLE && ptr_load) begin
                ptr    <= ptr_wdata;
                resume <= 1'b0;
            end
            if (!fetching)       word_idx <= '0;
            else if (mem_rvalid) word_idx <= word_idx + 2'd1;
            if (fetching && mem_rvalid) begin
                unique case (word_idx)
                    2'd0: link <= mem_rdata;
                    2'd1: if (state == ST_DREAD) begin
                        cmdsts    <= mem_rdata;
                        frag_left <= mem_rdata[CNT_W-1:0];
                    end
                    2'd2: if (state == ST_DREAD) bufptr <= mem_rdata;
                    default: ;
                endcase
            end
            if (state == ST_FBLOCK) begin
                cur_len   <= burst;
                xfer_left <= burst;
            end
            if (state == ST_FREAD) begin
                if (mem_rvalid)
                    xfer_left <= (xfer_left > WORD_LEN) ? xfer_left - WORD_LEN : '0;
                if (mem_done) begin
                    bufptr    <= bufptr + 32'(cur_len);
                    frag_left <= frag_left - cur_len;
                end
            end
            if (state == ST_ADVANCE) begin
                if (link != '0) begin
                    ptr    <= link;
                    resume <= 1'b0;
                end else begin
                    resume <= 1'b1;
                end
            end
        end
    end

    // R5: a burst begins only after enough FIFO room was reported
    p_space_before_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FREAD && $past(state) == ST_FBLOCK)
            |-> 32'($past(fifo_space)) >= 32'(cur_len));

    // R9: a null link leaves the pointer where it was
    p_null_link_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADVANCE && link_null) |=> $stable(ptr));
endmodule

// File: rtl/txd_bus_drive.sv
module txd_bus_drive
    import txd_pkg::*;
#(
    parameter int MAX_BURST = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  txd_state_e       state,
    input  logic [31:0]      ptr,
    input  logic [31:0]      cmdsts,
    input  logic [31:0]      bufptr,
    input  logic [CNT_W-1:0] cur_len,
    input  logic [CNT_W-1:0] xfer_left,
    input  logic [2:0]       tx_stat,
    input  logic             mem_rvalid,
    input  logic             mem_done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [CNT_W-1:0] mem_len,
    output logic [31:0]      mem_wdata,
    output logic             fifo_wr,
    output logic [2:0]       fifo_nbytes
);
    logic [31:0] wb_word;

    always_comb begin
        wb_word = cmdsts;
        wb_word[OWN_POS] = 1'b0;
        wb_word[STAT_MSB:STAT_LSB] = cmdsts[MORE_POS] ? 3'b000 : tx_stat;
    end

    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_len     = '0;
        mem_wdata   = '0;
        fifo_wr     = 1'b0;
        fifo_nbytes = '0;
        unique case (state)
            ST_REFRESH: begin
                mem_req  = 1'b1;
                mem_addr = ptr;
                mem_len  = WORD_LEN;
            end
            ST_DREAD: begin
                mem_req  = 1'b1;
                mem_addr = ptr;
                mem_len  = DESC_LEN;
            end
            ST_FREAD: begin
                mem_req     = 1'b1;
                mem_addr    = bufptr;
                mem_len     = cur_len;
                fifo_wr     = mem_rvalid;
                fifo_nbytes = (xfer_left >= WORD_LEN) ? 3'd4 : xfer_left[2:0];
            end
            ST_DWRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr + 32'd4;
                mem_len   = WORD_LEN;
                mem_wdata = wb_word;
            end
            default: ;
        endcase
    end

    // R1: nothing on the bus or into the FIFO while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!mem_req && !fifo_wr));

    // R2: a request holds steady until its completion
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));

    // R4: every burst is non-empty and within the cap
    p_burst_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && state == ST_FREAD)
            |-> (mem_len != '0 && 32'(mem_len) <= MAX_BURST));

    // R7: every write-back hands the descriptor back to the host
    p_own_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_wdata[OWN_POS]);
endmodule

// File: rtl/txd_walker.sv
module txd_walker
    import txd_pkg::*;
#(
    parameter int MAX_BURST = 64,
    parameter int SPACE_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_go,
    input  logic               ptr_load,
    input  logic [31:0]        ptr_wdata,
    input  logic [2:0]         tx_stat,
    input  logic [SPACE_W-1:0] fifo_space,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [11:0]        mem_len,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    input  logic               mem_rvalid,
    input  logic               mem_done,
    output logic               fifo_wr,
    output logic [31:0]        fifo_data,
    output logic [2:0]         fifo_nbytes,
    output logic [31:0]        desc_ptr,
    output logic               eng_idle,
    output logic [2:0]         eng_state
);
    txd_state_e       state;
    logic [31:0]      cmdsts;
    logic [31:0]      bufptr;
    logic [CNT_W-1:0] cur_len;
    logic [CNT_W-1:0] xfer_left;
    logic             owned;
    logic             resume;
    logic             frag_empty;
    logic             space_ok;
    logic             link_null;

    txd_walk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (tx_go),
        .ptr_load   (ptr_load),
        .mem_done   (mem_done),
        .owned      (owned),
        .resume     (resume),
        .frag_empty (frag_empty),
        .space_ok   (space_ok),
        .link_null  (link_null),
        .state      (state)
    );

    txd_desc_cache #(.MAX_BURST(MAX_BURST), .SPACE_W(SPACE_W)) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .ptr_load   (ptr_load),
        .ptr_wdata  (ptr_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_done   (mem_done),
        .fifo_space (fifo_space),
        .ptr        (desc_ptr),
        .cmdsts     (cmdsts),
        .bufptr     (bufptr),
        .cur_len    (cur_len),
        .xfer_left  (xfer_left),
        .owned      (owned),
        .resume     (resume),
        .frag_empty (frag_empty),
        .space_ok   (space_ok),
        .link_null  (link_null)
    );

    txd_bus_drive #(.MAX_BURST(MAX_BURST)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .ptr         (desc_ptr),
        .cmdsts      (cmdsts),
        .bufptr      (bufptr),
        .cur_len     (cur_len),
        .xfer_left   (xfer_left),
        .tx_stat     (tx_stat),
        .mem_rvalid  (mem_rvalid),
        .mem_done    (mem_done),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_len     (mem_len),
        .mem_wdata   (mem_wdata),
        .fifo_wr     (fifo_wr),
        .fifo_nbytes (fifo_nbytes)
    );

    assign fifo_data = mem_rdata;
    assign eng_idle  = (state == ST_IDLE);
    assign eng_state = state;
endmodule

// File: tb/txd_walker_tb_top.sv
module txd_walker_tb_top;
    localparam int MAXB = 16;
    localparam int SPW  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tx_go = 1'b0;
    logic            ptr_load = 1'b0;
    logic [31:0]     ptr_wdata = '0;
    logic [2:0]      tx_stat = '0;
    logic [SPW-1:0]  fifo_space = 12'd64;
    logic            mem_req, mem_we, fifo_wr, eng_idle;
    logic [31:0]     mem_addr, mem_wdata, fifo_data, desc_ptr;
    logic [11:0]     mem_len;
    logic [31:0]     mem_rdata = '0;
    logic            mem_rvalid = 1'b0;
    logic            mem_done = 1'b0;
    logic [2:0]      fifo_nbytes, eng_state;

    int checks = 0;
    int fails = 0;

    logic [31:0] mem [0:255];
    int          req_cnt = 0;
    logic [31:0] req_addr [0:63];
    logic [11:0] req_len  [0:63];
    logic        req_we   [0:63];
    logic [31:0] req_wd   [0:63];
    logic [7:0]  fb [0:255];
    int          fb_cnt = 0;

    always #5 clk = ~clk;

    txd_walker #(.MAX_BURST(MAXB), .SPACE_W(SPW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .ptr_load(ptr_load),
        .ptr_wdata(ptr_wdata), .tx_stat(tx_stat), .fifo_space(fifo_space),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .mem_done(mem_done), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .fifo_nbytes(fifo_nbytes), .desc_ptr(desc_ptr), .eng_idle(eng_idle),
        .eng_state(eng_state)
    );

    // host memory model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                logic [31:0] a;
                logic [11:0] l;
                a = mem_addr;
                l = mem_len;
                if (req_cnt < 64) begin
                    req_addr[req_cnt] = a;
                    req_len[req_cnt]  = l;
                    req_we[req_cnt]   = mem_we;
                    req_wd[req_cnt]   = mem_wdata;
                end
                req_cnt++;
                if (mem_we) begin
                    mem[a[9:2]] = mem_wdata;
                end else begin
                    for (int i = 0; i < (int'(l) + 3) / 4; i++) begin
                        @(negedge clk);
                        mem_rvalid = 1'b1;
                        mem_rdata  = mem[a[9:2] + 8'(i)];
                    end
                end
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_done   = 1'b1;
                @(negedge clk);
                mem_done   = 1'b0;
            end
        end
    end

    // FIFO byte collector
    always @(posedge clk) begin
        if (rst_n && fifo_wr) begin
            for (int b = 0; b < 4; b++)
                if (b < int'(fifo_nbytes) && fb_cnt < 256) begin
                    fb[fb_cnt] = fifo_data[8*b +: 8];
                    fb_cnt++;
                end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] host_byte(input int a);
        return mem[a[9:2]][8*(a%4) +: 8];
    endfunction

    task automatic chk_bytes(input string tag, input int base, input int n, input int off);
        for (int i = 0; i < n; i++)
            chk(tag, {24'h0, fb[off+i]}, {24'h0, host_byte(base + i)});
    endtask

    task automatic chk_req(input string tag, input int idx, input logic [31:0] a,
                           input logic [11:0] l, input logic we);
        chk({tag, " addr"}, req_addr[idx], a);
        chk({tag, " len"}, {20'h0, req_len[idx]}, {20'h0, l});
        chk({tag, " dir"}, {31'h0, req_we[idx]}, {31'h0, we});
    endtask

    task automatic clear_logs();
        req_cnt = 0;
        fb_cnt  = 0;
    endtask

    task automatic load_ptr(input logic [31:0] p);
        @(negedge clk);
        ptr_wdata = p;
        ptr_load  = 1'b1;
        @(negedge clk);
        ptr_load  = 1'b0;
    endtask

    task automatic pulse_go();
        @(negedge clk);
        tx_go = 1'b1;
        @(negedge clk);
        tx_go = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (eng_idle && !mem_done && !mem_rvalid) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 idle after reset", {31'h0, eng_idle}, 32'd1);
        chk("R1 state code", {29'h0, eng_state}, 32'd0);
        chk("R1 ptr", desc_ptr, 32'h0);
        chk("R1 no req", {31'h0, mem_req}, 32'd0);
        chk("R1 no fifo write", {31'h0, fifo_wr}, 32'd0);
    endtask

    // single descriptor, 10 bytes, last of packet
    task automatic t_single();
        mem[8'h40] = 32'h0;
        mem[8'h41] = 32'h8000_000A;
        mem[8'h42] = 32'h0000_0200;
        tx_stat = 3'b010;
        clear_logs();
        load_ptr(32'h100);
        pulse_go();
        wait_idle();
        chk("R2 req count", req_cnt, 3);
        chk_req("R2 desc read", 0, 32'h100, 12'd12, 1'b0);
        chk_req("R4 frag read", 1, 32'h200, 12'd10, 1'b0);
        chk_req("R7 write-back", 2, 32'h104, 12'd4, 1'b1);
        chk("R7 status word", mem[8'h41], 32'h0200_000A);
        chk("R4 byte count", fb_cnt, 10);
        chk_bytes("R4 bytes", 32'h200, 10, 0);
        chk("R9 ptr kept on null link", desc_ptr, 32'h100);
        chk("R9 idle", {31'h0, eng_idle}, 32'd1);
    endtask

    // unowned descriptor; pointer load clears the completed mark
    task automatic t_unowned();
        mem[8'h50] = 32'h0000_0180;
        mem[8'h51] = 32'h0000_0008;
        mem[8'h52] = 32'h0000_0200;
        clear_logs();
        load_ptr(32'h140);
        pulse_go();
        wait_idle();
        chk("R11 fresh fetch after load", req_cnt, 1);
        chk_req("R11 desc read not refresh", 0, 32'h140, 12'd12, 1'b0);
        chk("R3 no fifo data", fb_cnt, 0);
        chk("R3 no write-back", mem[8'h51], 32'h0000_0008);
        chk("R3 ptr", desc_ptr, 32'h140);
        chk("R3 idle", {31'h0, eng_idle}, 32'd1);
    endtask

    // two-descriptor packet with FIFO stall
    task automatic t_chain();
        mem[8'h60] = 32'h0000_01C0;
        mem[8'h61] = 32'hC000_0014;
        mem[8'h62] = 32'h0000_0240;
        mem[8'h70] = 32'h0;
        mem[8'h71] = 32'h8000_0006;
        mem[8'h72] = 32'h0000_0280;
        tx_stat    = 3'b101;
        fifo_space = 12'd8;
        clear_logs();
        load_ptr(32'h180);
        pulse_go();
        repeat (40) @(negedge clk);
        chk("R5 stalled state", {29'h0, eng_state}, 32'd3);
        chk("R5 no frag read", req_cnt, 1);
        chk("R5 no fifo data", fb_cnt, 0);
        fifo_space = 12'd64;
        wait_idle();
        chk("R6 req count", req_cnt, 7);
        chk_req("R4 burst 1", 1, 32'h240, 12'd16, 1'b0);
        chk_req("R4 burst 2", 2, 32'h250, 12'd4, 1'b0);
        chk_req("R8 mid write-back", 3, 32'h184, 12'd4, 1'b1);
        chk("R8 mid status", mem[8'h61], 32'h4000_0014);
        chk_req("R9 follow link", 4, 32'h1C0, 12'd12, 1'b0);
        chk_req("R6 second frag", 5, 32'h280, 12'd6, 1'b0);
        chk("R7 last status", mem[8'h71], 32'h0500_0006);
        chk("R6 byte count", fb_cnt, 26);
        chk_bytes("R6 first bytes", 32'h240, 20, 0);
        chk_bytes("R6 second bytes", 32'h280, 6, 20);
        chk("R9 ptr at last", desc_ptr, 32'h1C0);
    endtask

    // refresh after end of list, then zero-length descriptor
    task automatic t_refresh();
        mem[8'h70] = 32'h0000_0300;
        mem[8'hC0] = 32'h0;
        mem[8'hC1] = 32'h8000_0000;
        mem[8'hC2] = 32'h0000_0200;
        tx_stat = 3'b001;
        clear_logs();
        pulse_go();
        wait_idle();
        chk("R10 req count", req_cnt, 3);
        chk_req("R10 link re-read", 0, 32'h1C0, 12'd4, 1'b0);
        chk_req("R10 next desc", 1, 32'h300, 12'd12, 1'b0);
        chk_req("R12 direct write-back", 2, 32'h304, 12'd4, 1'b1);
        chk("R12 status", mem[8'hC1], 32'h0100_0000);
        chk("R12 no fifo data", fb_cnt, 0);
        chk("R10 ptr", desc_ptr, 32'h300);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++)
            mem[i] = {8'hA5, 8'(i), 8'(i * 3), 8'(i + 7)};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_unowned();
        t_chain();
        t_refresh();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule